// File: doc/BRIEF.md
# Oversampling Serial Receive Engine

This block turns an asynchronous serial line into characters. The line passes through a synchronizer. A falling edge seen while the receiver is switched on starts a frame, and a one-cycle strobe at sixteen times the bit rate drives every later decision. Each bit is decided by a two-out-of-three vote over three consecutive samples. Where those three samples fall depends on whether the bit is the start bit, a data or parity bit, or a stop bit. For a stop bit it also depends on the configured stop length.

The decided data and parity bits collect in a shift register of up to ten positions. When the last stop bit has been decided, the character goes to a downstream store over a valid/ready port. A one-cycle flag marks any stop bit that was read as 0. In wake-up mode only characters whose bit 8 is 1 go out. The rate generator and the character store sit outside this block.

Top module: `ovs_uart_rx`

## Requirements
- R1: A frame starts only on a high-to-low change of the synchronized line, and only while `run` and `rx_en` are both 1.
- R2: The start bit is the majority of samples 1, 2 and 3 after the edge, where sample 1 is the first strobe after the edge is seen. If that majority is 1, the receiver goes back to idle and sends no character.
- R3: Each data or parity bit is the majority of samples 7, 8 and 9 of its 16-sample period. A single disturbed sample inside that window does not change the bit.
- R4: Bits are received LSB first. The i-th bit after the start bit lands in `out_data[i]`, for `bit_count` bits, and unused upper positions read 0.
- R5: The stop-bit vote window follows `stop_len`. Code 0 (half bit) votes on samples 3-5. Code 1 (one bit) votes on samples 7-9. Code 2 (one and a half bits) votes on samples 15-17. Code 3 (two bits) votes on samples 7-9 of each of the two stop bits.
- R6: `frame_err` is high for exactly one cycle when any stop vote of a frame is 0. The character is still delivered, subject to R7.
- R7: When `wake_mode` is 1, a character is delivered only if its bit 8 is 1.
- R8: Clearing `run` or `rx_en` during a frame abandons it, and no character comes out of it.
- R9: Once `out_valid` is 1 it stays 1, with `out_data` unchanged, until the cycle after `out_ready` is 1. A character that finishes while an older one is still waiting replaces it.
- R10: During reset `out_valid` and `frame_err` are 0.
- R11: After a frame the receiver waits for the next falling edge, so a frame whose start bit directly follows the previous stop bit is received as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_16x | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| run | input | 1 | Global receiver enable |
| rx_en | input | 1 | Receive enable |
| wake_mode | input | 1 | Deliver only characters with bit 8 set |
| bit_count | input | 4 | Data plus parity bits per frame, 1 to 10 (0 acts as 1, above 10 as 10) |
| stop_len | input | 2 | Stop length code: 0 half, 1 one, 2 one and a half, 3 two |
| out_valid | output | 1 | Character available |
| out_ready | input | 1 | Downstream accepts the character |
| out_data | output | 10 | Received character, bit 0 first on the line |
| frame_err | output | 1 | One-cycle pulse: a stop bit was read as 0 |

## Verification
Clean frames of 8, 9 and 10 bits with varied values check bit ordering. A one-strobe disturbance placed inside the mid-bit window shows whether a vote is taken or a single sample is trusted. A short low pulse on the idle line must be recognized as a false start. Stop bits that are low only for part of their length are placed so that a window in the wrong position gives the opposite error verdict for half, one-and-a-half and two stop bits. Wake-up frames that differ only in bit 8, frames sent while disabled or disabled partway through, back-to-back frames and a held ready line cover the gating, restart and hand-off rules.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

  typedef enum logic [1:0] {
    STOP_HALF     = 2'd0,
    STOP_ONE      = 2'd1,
    STOP_ONE_HALF = 2'd2,
    STOP_TWO      = 2'd3
  } stop_len_e;

  typedef enum logic [2:0] {
    RX_IDLE   = 3'd0,
    RX_START  = 3'd1,
    RX_DATA   = 3'd2,
    RX_STOP_A = 3'd3,
    RX_STOP_B = 3'd4
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/ovs_rx_sync.sv
module ovs_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line,
  output logic fall
);
  logic chain [STAGES];
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= 1'b1;
      prev <= 1'b1;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign line = chain[STAGES-1];
  assign fall = prev & ~line;
endmodule

// File: rtl/ovs_rx_vote3.sv
module ovs_rx_vote3
  import ovs_rx_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_en,
  input  logic          din,
  input  logic [CW-1:0] pos,
  input  logic [CW-1:0] win,
  output logic          done,
  output logic          bit_out
);
  logic          s0, s1;
  logic [CW-1:0] win1, win2;

  assign win1 = win + CW'(1);
  assign win2 = win + CW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 1'b1;
      s1 <= 1'b1;
    end else if (sample_en) begin
      if (pos == win)  s0 <= din;
      if (pos == win1) s1 <= din;
    end
  end

  assign done    = sample_en && (pos == win2);
  assign bit_out = maj3(s0, s1, din);
endmodule

// File: rtl/ovs_rx_ctl.sv
module ovs_rx_ctl
  import ovs_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int FW  = 10,
  parameter int BCW = $clog2(FW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           line,
  input  logic           fall,
  input  logic           run,
  input  logic           rx_en,
  input  logic           wake_mode,
  input  logic [BCW-1:0] bit_count,
  input  logic [1:0]     stop_len,
  output logic           push,
  output logic [FW-1:0]  push_data,
  output logic           frame_err,
  output logic           busy,
  output logic           wake_q
);
  localparam int CW       = $clog2(2 * OVS) + 1;
  localparam int IW       = $clog2(FW);
  localparam int WAKE_BIT = FW - 2;
  localparam logic [CW-1:0] W_START = CW'(1);
  localparam logic [CW-1:0] W_MID   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] W_HALF  = CW'(OVS / 4 - 1);
  localparam logic [CW-1:0] W_LATE  = CW'(OVS - 1);
  localparam logic [CW-1:0] W_NONE  = '1;
  localparam logic [CW-1:0] BIT_END = CW'(OVS);

  rx_state_e     state;
  stop_len_e     stop_q;
  logic [CW-1:0] samp, samp_n, win;
  logic [IW-1:0] idx, last_idx;
  logic [FW-1:0] shreg;
  logic          err_acc, push_q, ferr_q;
  logic          active, v_done, v_bit;

  assign active = run & rx_en;
  assign samp_n = samp + CW'(1);

  always_comb begin
    unique case (state)
      RX_START:  win = W_START;
      RX_DATA:   win = W_MID;
      RX_STOP_A: begin
        unique case (stop_q)
          STOP_HALF:     win = W_HALF;
          STOP_ONE_HALF: win = W_LATE;
          default:       win = W_MID;
        endcase
      end
      RX_STOP_B: win = W_MID;
      default:   win = W_NONE;
    endcase
  end

  ovs_rx_vote3 #(.CW(CW)) u_vote (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_en(tick && (state != RX_IDLE)),
    .din      (line),
    .pos      (samp_n),
    .win      (win),
    .done     (v_done),
    .bit_out  (v_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      stop_q   <= STOP_ONE;
      wake_q   <= 1'b0;
      samp     <= '0;
      idx      <= '0;
      last_idx <= '0;
      shreg    <= '0;
      err_acc  <= 1'b0;
      push_q   <= 1'b0;
      ferr_q   <= 1'b0;
    end else begin
      push_q <= 1'b0;
      ferr_q <= 1'b0;
      if (!active) begin
        state <= RX_IDLE;
      end else begin
        unique case (state)
          RX_IDLE: begin
            if (fall) begin
              state   <= RX_START;
              samp    <= '0;
              idx     <= '0;
              shreg   <= '0;
              err_acc <= 1'b0;
              stop_q  <= stop_len_e'(stop_len);
              wake_q  <= wake_mode;
              if (bit_count == '0)             last_idx <= '0;
              else if (bit_count > BCW'(FW))   last_idx <= IW'(FW - 1);
              else                             last_idx <= IW'(bit_count - BCW'(1));
            end
          end
          RX_START: if (tick) begin
            samp <= samp_n;
            if (v_done && v_bit) begin
              state <= RX_IDLE;
            end else if (samp_n == BIT_END) begin
              state <= RX_DATA;
              samp  <= '0;
            end
          end
          RX_DATA: if (tick) begin
            samp <= samp_n;
            if (v_done) shreg[idx] <= v_bit;
            if (samp_n == BIT_END) begin
              samp <= '0;
              if (idx == last_idx) state <= RX_STOP_A;
              else                 idx   <= idx + IW'(1);
            end
          end
          RX_STOP_A: if (tick) begin
            samp <= samp_n;
            if (v_done) begin
              if (stop_q == STOP_TWO) begin
                err_acc <= ~v_bit;
              end else begin
                state  <= RX_IDLE;
                push_q <= ~wake_q | shreg[WAKE_BIT];
                ferr_q <= ~v_bit;
              end
            end
            if (stop_q == STOP_TWO && samp_n == BIT_END) begin
              state <= RX_STOP_B;
              samp  <= '0;
            end
          end
          RX_STOP_B: if (tick) begin
            samp <= samp_n;
            if (v_done) begin
              state  <= RX_IDLE;
              push_q <= ~wake_q | shreg[WAKE_BIT];
              ferr_q <= err_acc | ~v_bit;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign push      = push_q;
  assign push_data = shreg;
  assign frame_err = ferr_q;
  assign busy      = (state != RX_IDLE);
endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx
  import ovs_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int FW          = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_16x,
  input  logic          rxd,
  input  logic          run,
  input  logic          rx_en,
  input  logic          wake_mode,
  input  logic [3:0]    bit_count,
  input  logic [1:0]    stop_len,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [FW-1:0] out_data,
  output logic          frame_err
);
  logic          line, fall, push, busy, wake_q;
  logic [FW-1:0] push_data;

  ovs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .line (line),
    .fall (fall)
  );

  ovs_rx_ctl #(.OVS(OVS), .FW(FW), .BCW(4)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_16x),
    .line     (line),
    .fall     (fall),
    .run      (run),
    .rx_en    (rx_en),
    .wake_mode(wake_mode),
    .bit_count(bit_count),
    .stop_len (stop_len),
    .push     (push),
    .push_data(push_data),
    .frame_err(frame_err),
    .busy     (busy),
    .wake_q   (wake_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= push_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ovs_uart_rx_chk.sv
module ovs_uart_rx_chk #(
  parameter int FW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          rx_en,
  input logic          fall,
  input logic          busy,
  input logic          push,
  input logic          wake_q,
  input logic          out_valid,
  input logic          out_ready,
  input logic [FW-1:0] out_data,
  input logic          frame_err
);
  p_start_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(run && rx_en && fall));

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  p_wake_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && wake_q |-> out_data[FW-2]);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && rx_en) |=> !busy);

  p_hold_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !push |=> $stable(out_data));

  always_comb begin
    if (!rst_n) begin
      a_reset_r10: assert (!out_valid && !frame_err);
    end
  end
endmodule

bind ovs_uart_rx ovs_uart_rx_chk #(.FW(FW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .rx_en    (rx_en),
  .fall     (fall),
  .busy     (busy),
  .push     (push),
  .wake_q   (wake_q),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .frame_err(frame_err)
);

// File: tb/sim_ovs_uart_rx.sv
`timescale 1ns/1ps
module sim_ovs_uart_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16x = 1'b0;
  logic       rxd = 1'b1;
  logic       run = 1'b1;
  logic       rx_en = 1'b1;
  logic       wake_mode = 1'b0;
  logic [3:0] bit_count = 4'd8;
  logic [1:0] stop_len = 2'd1;
  logic       out_ready = 1'b1;
  logic       out_valid;
  logic [9:0] out_data;
  logic       frame_err;

  int total = 0;
  int bad = 0;
  int got_cnt = 0;
  int ferr_cnt = 0;
  logic [9:0] got_last = '0;
  logic [9:0] got_prev = '0;
  bit finished = 1'b0;
  logic [1:0] tc = '0;

  always #4 clk = ~clk;

  ovs_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rxd(rxd),
    .run(run), .rx_en(rx_en), .wake_mode(wake_mode),
    .bit_count(bit_count), .stop_len(stop_len),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    tc <= tc + 2'd1;
    tick_16x <= (tc == 2'd3);
  end

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      got_cnt++;
      got_prev = got_last;
      got_last = out_data;
    end
    if (rst_n && frame_err) ferr_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_t(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [9:0] d, input int nb, input int lo_a,
                            input int lo_n, input int stop_t, input int gbit);
    rxd = 1'b0;
    wait_t(16);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      if (i == gbit) begin
        wait_t(7); rxd = ~d[i]; wait_t(1); rxd = d[i]; wait_t(8);
      end else begin
        wait_t(16);
      end
    end
    for (int t = 0; t < stop_t; t++) begin
      rxd = !(t >= lo_a && t < lo_a + lo_n);
      wait_t(1);
    end
    rxd = 1'b1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid in reset", out_valid, 0);
    chk(frame_err == 1'b0, "R10 frame_err in reset", frame_err, 0);
    rst_n = 1'b1;
    wait_t(4);
  endtask

  task automatic t_basic();
    int c0 = got_cnt; int f0 = ferr_cnt;
    bit_count = 4'd8; stop_len = 2'd1;
    send_frame(10'h0A5, 8, 0, 0, 48, -1);
    chk(got_cnt == c0 + 1, "R4 one char", got_cnt - c0, 1);
    chk(got_last == 10'h0A5, "R4 8-bit data", got_last, 10'h0A5);
    chk(ferr_cnt == f0, "R5 clean one stop", ferr_cnt - f0, 0);
    bit_count = 4'd10;
    send_frame(10'h2C3, 10, 0, 0, 48, -1);
    chk(got_last == 10'h2C3, "R4 10-bit data", got_last, 10'h2C3);
    bit_count = 4'd8;
  endtask

  task automatic t_glitch();
    send_frame(10'h000, 8, 0, 0, 48, 3);
    chk(got_last == 10'h000, "R3 high glitch outvoted", got_last, 0);
    send_frame(10'h0FF, 8, 0, 0, 48, 5);
    chk(got_last == 10'h0FF, "R3 low glitch outvoted", got_last, 10'h0FF);
  endtask

  task automatic t_false_start();
    int c0 = got_cnt;
    rxd = 1'b0; repeat (2) @(negedge clk); rxd = 1'b1;
    wait_t(48);
    chk(got_cnt == c0, "R2 false start gives nothing", got_cnt - c0, 0);
    send_frame(10'h03C, 8, 0, 0, 48, -1);
    chk(got_cnt == c0 + 1 && got_last == 10'h03C, "R2 recovers after false start", got_last, 10'h03C);
  endtask

  task automatic t_back_to_back();
    int c0 = got_cnt;
    send_frame(10'h011, 8, 0, 0, 16, -1);
    send_frame(10'h0EE, 8, 0, 0, 48, -1);
    chk(got_cnt == c0 + 2, "R11 two back-to-back chars", got_cnt - c0, 2);
    chk(got_prev == 10'h011, "R11 first char", got_prev, 10'h011);
    chk(got_last == 10'h0EE, "R11 second char", got_last, 10'h0EE);
  endtask

  task automatic t_stops();
    int c0; int f0;
    c0 = got_cnt; f0 = ferr_cnt;
    stop_len = 2'd0;
    send_frame(10'h05A, 8, 0, 6, 48, -1);
    chk(ferr_cnt == f0 + 1, "R5 half stop votes early (R6 one pulse)", ferr_cnt - f0, 1);
    chk(got_cnt == c0 + 1 && got_last == 10'h05A, "R6 char kept on frame error", got_last, 10'h05A);
    f0 = ferr_cnt;
    stop_len = 2'd2;
    send_frame(10'h066, 8, 0, 12, 48, -1);
    chk(ferr_cnt == f0, "R5 one-and-half stop votes late", ferr_cnt - f0, 0);
    chk(got_last == 10'h066, "R5 one-and-half data", got_last, 10'h066);
    f0 = ferr_cnt;
    stop_len = 2'd3;
    send_frame(10'h081, 8, 16, 16, 48, -1);
    chk(ferr_cnt == f0 + 1, "R5 second of two stops checked", ferr_cnt - f0, 1);
    f0 = ferr_cnt;
    send_frame(10'h042, 8, 0, 0, 48, -1);
    chk(ferr_cnt == f0 && got_last == 10'h042, "R5 two clean stops", ferr_cnt - f0, 0);
    stop_len = 2'd1;
  endtask

  task automatic t_wake();
    int c0 = got_cnt;
    wake_mode = 1'b1; bit_count = 4'd9;
    send_frame(10'h0FF, 9, 0, 0, 48, -1);
    chk(got_cnt == c0, "R7 bit8 clear dropped", got_cnt - c0, 0);
    send_frame(10'h155, 9, 0, 0, 48, -1);
    chk(got_cnt == c0 + 1 && got_last == 10'h155, "R7 bit8 set delivered", got_last, 10'h155);
    wake_mode = 1'b0; bit_count = 4'd8;
  endtask

  task automatic t_enable();
    int c0 = got_cnt;
    run = 1'b0;
    send_frame(10'h0AA, 8, 0, 0, 48, -1);
    run = 1'b1;
    chk(got_cnt == c0, "R1 ignored while run low", got_cnt - c0, 0);
    rx_en = 1'b0;
    send_frame(10'h0AA, 8, 0, 0, 48, -1);
    rx_en = 1'b1;
    chk(got_cnt == c0, "R1 ignored while rx_en low", got_cnt - c0, 0);
    fork
      send_frame(10'h0AA, 8, 0, 0, 48, -1);
      begin wait_t(80); rx_en = 1'b0; end
    join
    rx_en = 1'b1;
    wait_t(4);
    chk(got_cnt == c0, "R8 mid-frame disable aborts", got_cnt - c0, 0);
  endtask

  task automatic t_backpressure();
    int c0 = got_cnt;
    out_ready = 1'b0;
    send_frame(10'h0C1, 8, 0, 0, 48, -1);
    chk(out_valid == 1'b1 && out_data == 10'h0C1, "R9 held first char", out_data, 10'h0C1);
    send_frame(10'h0D2, 8, 0, 0, 48, -1);
    chk(out_valid == 1'b1 && out_data == 10'h0D2, "R9 newer char replaces", out_data, 10'h0D2);
    chk(got_cnt == c0, "R9 nothing taken while not ready", got_cnt - c0, 0);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(got_cnt == c0 + 1 && out_valid == 1'b0, "R9 single hand-off", got_cnt - c0, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_glitch();
    t_false_start();
    t_back_to_back();
    t_stops();
    t_wake();
    t_enable();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule